// File: doc/BRIEF.md
# Card Bus Byte-Lane Steering

This block sits between a 16-bit removable-card data bus and two 8-bit storage banks, one holding even-addressed bytes and one holding odd-addressed bytes, plus a separate byte-wide attribute store. It reads the two active-low lane enables, address bit 0, the output and write enables and an attribute-space select. From these it decides which byte goes on which half of the bus, whether each half is driven at all, and which bank gets a write strobe with which byte.

In a byte access through the low lane, address bit 0 picks the bank, so an odd byte can show up on D7-D0. In an access through the high lane only, the odd bank always uses D15-D8. In the attribute space only even bytes exist: odd-position reads return a fixed fill byte, and odd-position writes go nowhere. Writes to the common banks go through only while the programming-voltage-good input for that bank is high. Every output is registered, so each result appears one clock after the inputs that caused it.

Top module: `pc_lane_steer`

## Requirements
- R1: Read, common space, only the low-lane enable (`ce_lo_n`=0, `ce_hi_n`=1): `lo_en`=1 and `rdata[7:0]` carries `even_rd` when `a0`=0 or `odd_rd` when `a0`=1. `hi_en`=0 and `rdata[15:8]`=0.
- R2: Read, common space, only the high-lane enable: `hi_en`=1 and `rdata[15:8]`=`odd_rd` for either value of `a0`. `lo_en`=0 and `rdata[7:0]`=0.
- R3: Read, common space, both enables low: `rdata`={`odd_rd`,`even_rd`} with both lanes enabled, for either value of `a0`.
- R4: With both lane enables high, or with both `oe_n` and `we_n` high, neither lane is enabled, `rdata`=0 and no write strobe fires.
- R5: Write, common space, banks enabled for programming. Low-lane only: `a0`=0 strobes the even bank and `a0`=1 strobes the odd bank, each with `wdata[7:0]`. High-lane only: strobes the odd bank with `wdata[15:8]`. Both lanes: strobes the even bank with `wdata[7:0]` and the odd bank with `wdata[15:8]`.
- R6: Attribute space (`attr_sel`=1). A read places `attr_rd` on the low lane at even positions (low-only with `a0`=0, or both lanes). Any odd position (low-only with `a0`=1, or the high lane) reads 8'hFF. A write strobes `attr_we` with `wdata[7:0]` only for an even position, and the common banks never get a strobe.
- R7: A common-space write strobes the even bank only while `vpp_ok_even`=1 and the odd bank only while `vpp_ok_odd`=1.
- R8: If `oe_n` and `we_n` are both low, the access is a write: the strobes follow R5 to R7 and both lanes stay disabled.
- R9: All outputs are registered and show the effect of the inputs one clock later. Synchronous reset clears every output to 0. Any write-data output whose strobe is low reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_lo_n | input | 1 | Low-lane enable, active low |
| ce_hi_n | input | 1 | High-lane enable, active low |
| a0 | input | 1 | Address bit 0 |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| attr_sel | input | 1 | Selects attribute space when high |
| vpp_ok_even | input | 1 | Programming voltage good, even bank |
| vpp_ok_odd | input | 1 | Programming voltage good, odd bank |
| wdata | input | 16 | Write data from the card bus |
| even_rd | input | 8 | Read byte from the even bank |
| odd_rd | input | 8 | Read byte from the odd bank |
| attr_rd | input | 8 | Read byte from the attribute store |
| rdata | output | 16 | Steered read data toward the card bus |
| lo_en | output | 1 | Drive enable for D7-D0 |
| hi_en | output | 1 | Drive enable for D15-D8 |
| even_we | output | 1 | Even bank write strobe |
| even_wd | output | 8 | Even bank write byte |
| odd_we | output | 1 | Odd bank write strobe |
| odd_wd | output | 8 | Odd bank write byte |
| attr_we | output | 1 | Attribute store write strobe |
| attr_wd | output | 8 | Attribute store write byte |

## Verification
The assertions assume the control inputs and bank read bytes are steady, known values at each rising edge, and that the bank read bytes change only between edges. The properties compare outputs with the inputs of the previous edge, so they depend on this. The bench changes every input only on the falling clock edge and draws all values from $urandom, so no input is ever unknown or changing at a rising edge. It weights the lane-enable and strobe draws so that standby, reads, writes, the overlap of output and write enable, and both attribute positions all occur many times, next to a short directed list of each corner.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;
  typedef enum logic [1:0] {LN_NONE, LN_LO, LN_HI, LN_WORD} lane_sel_e;
  typedef enum logic [1:0] {OP_IDLE, OP_READ, OP_WRITE} bus_op_e;
endpackage

// File: rtl/pcs_decode.sv
module pcs_decode
  import pc_steer_pkg::*;
(
  input  logic      ce_lo_n,
  input  logic      ce_hi_n,
  input  logic      oe_n,
  input  logic      we_n,
  output lane_sel_e lanes,
  output bus_op_e   op
);
  always_comb begin
    case ({ce_hi_n, ce_lo_n})
      2'b10:   lanes = LN_LO;
      2'b01:   lanes = LN_HI;
      2'b00:   lanes = LN_WORD;
      default: lanes = LN_NONE;
    endcase
  end

  // write enable dominates output enable
  always_comb begin
    if (lanes == LN_NONE)  op = OP_IDLE;
    else if (!we_n)        op = OP_WRITE;
    else if (!oe_n)        op = OP_READ;
    else                   op = OP_IDLE;
  end
endmodule

// File: rtl/pcs_read_mux.sv
module pcs_read_mux
  import pc_steer_pkg::*;
#(
  parameter int          BW   = 8,
  parameter logic [BW-1:0] FILL = '1
) (
  input  bus_op_e         op,
  input  lane_sel_e       lanes,
  input  logic            a0,
  input  logic            attr_sel,
  input  logic [BW-1:0]   even_rd,
  input  logic [BW-1:0]   odd_rd,
  input  logic [BW-1:0]   attr_rd,
  output logic [2*BW-1:0] rd_nxt,
  output logic            lo_en_nxt,
  output logic            hi_en_nxt
);
  logic use_lo, use_hi;
  logic [BW-1:0] lo_byte, hi_byte;

  assign use_lo = (op == OP_READ) && (lanes == LN_LO || lanes == LN_WORD);
  assign use_hi = (op == OP_READ) && (lanes == LN_HI || lanes == LN_WORD);

  always_comb begin
    if (attr_sel) begin
      lo_byte = (lanes == LN_LO && a0) ? FILL : attr_rd;
      hi_byte = FILL;
    end else begin
      lo_byte = (lanes == LN_LO && a0) ? odd_rd : even_rd;
      hi_byte = odd_rd;
    end
  end

  assign lo_en_nxt = use_lo;
  assign hi_en_nxt = use_hi;
  assign rd_nxt    = {(use_hi ? hi_byte : '0), (use_lo ? lo_byte : '0)};
endmodule

// File: rtl/pcs_write_route.sv
module pcs_write_route
  import pc_steer_pkg::*;
#(
  parameter int BW = 8
) (
  input  bus_op_e         op,
  input  lane_sel_e       lanes,
  input  logic            a0,
  input  logic            attr_sel,
  input  logic            vpp_ok_even,
  input  logic            vpp_ok_odd,
  input  logic [2*BW-1:0] wdata,
  output logic            even_we_nxt,
  output logic [BW-1:0]   even_wd_nxt,
  output logic            odd_we_nxt,
  output logic [BW-1:0]   odd_wd_nxt,
  output logic            attr_we_nxt,
  output logic [BW-1:0]   attr_wd_nxt
);
  logic [BW-1:0] lo_in, hi_in;
  logic wr_c, wr_a;
  logic ev_hit, od_hit;
  logic [BW-1:0] od_src;

  assign lo_in = wdata[BW-1:0];
  assign hi_in = wdata[2*BW-1:BW];
  assign wr_c  = (op == OP_WRITE) && !attr_sel;
  assign wr_a  = (op == OP_WRITE) && attr_sel;

  always_comb begin
    ev_hit = 1'b0;
    od_hit = 1'b0;
    od_src = hi_in;
    case (lanes)
      LN_LO: begin
        ev_hit = !a0;
        od_hit = a0;
        od_src = lo_in;
      end
      LN_HI:   od_hit = 1'b1;
      LN_WORD: begin
        ev_hit = 1'b1;
        od_hit = 1'b1;
      end
      default: ;
    endcase
  end

  assign even_we_nxt = wr_c && ev_hit && vpp_ok_even;
  assign odd_we_nxt  = wr_c && od_hit && vpp_ok_odd;
  assign even_wd_nxt = even_we_nxt ? lo_in : '0;
  assign odd_wd_nxt  = odd_we_nxt ? od_src : '0;

  // attribute space: even position only, no voltage gate
  assign attr_we_nxt = wr_a && ev_hit;
  assign attr_wd_nxt = attr_we_nxt ? lo_in : '0;
endmodule

// File: rtl/pc_lane_steer.sv
module pc_lane_steer
  import pc_steer_pkg::*;
#(
  parameter int            BW    = 8,
  parameter logic [BW-1:0] FILL  = '1,
  localparam int           LANES = 2,
  localparam int           DW    = LANES * BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ce_lo_n,
  input  logic          ce_hi_n,
  input  logic          a0,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          attr_sel,
  input  logic          vpp_ok_even,
  input  logic          vpp_ok_odd,
  input  logic [DW-1:0] wdata,
  input  logic [BW-1:0] even_rd,
  input  logic [BW-1:0] odd_rd,
  input  logic [BW-1:0] attr_rd,
  output logic [DW-1:0] rdata,
  output logic          lo_en,
  output logic          hi_en,
  output logic          even_we,
  output logic [BW-1:0] even_wd,
  output logic          odd_we,
  output logic [BW-1:0] odd_wd,
  output logic          attr_we,
  output logic [BW-1:0] attr_wd
);
  lane_sel_e lanes;
  bus_op_e   op;
  logic [DW-1:0]    rd_nxt;
  logic [LANES-1:0] en_nxt, en_q;
  logic             ew_n, ow_n, aw_n;
  logic [BW-1:0]    ewd_n, owd_n, awd_n;

  pcs_decode dec_i (
    .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .oe_n(oe_n), .we_n(we_n),
    .lanes(lanes), .op(op)
  );

  pcs_read_mux #(.BW(BW), .FILL(FILL)) rmux_i (
    .op(op), .lanes(lanes), .a0(a0), .attr_sel(attr_sel),
    .even_rd(even_rd), .odd_rd(odd_rd), .attr_rd(attr_rd),
    .rd_nxt(rd_nxt), .lo_en_nxt(en_nxt[0]), .hi_en_nxt(en_nxt[1])
  );

  pcs_write_route #(.BW(BW)) wrt_i (
    .op(op), .lanes(lanes), .a0(a0), .attr_sel(attr_sel),
    .vpp_ok_even(vpp_ok_even), .vpp_ok_odd(vpp_ok_odd), .wdata(wdata),
    .even_we_nxt(ew_n), .even_wd_nxt(ewd_n),
    .odd_we_nxt(ow_n), .odd_wd_nxt(owd_n),
    .attr_we_nxt(aw_n), .attr_wd_nxt(awd_n)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        rdata[g*BW +: BW] <= '0;
        en_q[g]           <= 1'b0;
      end else begin
        rdata[g*BW +: BW] <= rd_nxt[g*BW +: BW];
        en_q[g]           <= en_nxt[g];
      end
    end
  end

  assign lo_en = en_q[0];
  assign hi_en = en_q[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      even_we <= 1'b0;
      odd_we  <= 1'b0;
      attr_we <= 1'b0;
      even_wd <= '0;
      odd_wd  <= '0;
      attr_wd <= '0;
    end else begin
      even_we <= ew_n;
      odd_we  <= ow_n;
      attr_we <= aw_n;
      even_wd <= ewd_n;
      odd_wd  <= owd_n;
      attr_wd <= awd_n;
    end
  end
endmodule

// File: rtl/pc_lane_steer_chk.sv
module pc_lane_steer_chk #(
  parameter int BW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          ce_lo_n,
  input logic          ce_hi_n,
  input logic          a0,
  input logic          oe_n,
  input logic          we_n,
  input logic          attr_sel,
  input logic          vpp_ok_even,
  input logic          vpp_ok_odd,
  input logic [BW-1:0] even_rd,
  input logic [BW-1:0] odd_rd,
  input logic [2*BW-1:0] rdata,
  input logic          lo_en,
  input logic          hi_en,
  input logic          even_we,
  input logic          odd_we,
  input logic          attr_we
);
  // R4
  standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (ce_lo_n && ce_hi_n) |=> (!lo_en && !hi_en && !even_we && !odd_we && !attr_we));

  // R2
  hi_only_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!attr_sel && ce_lo_n && !ce_hi_n && !oe_n && we_n)
      |=> (hi_en && !lo_en && rdata[2*BW-1:BW] == $past(odd_rd)));

  // R3
  word_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!attr_sel && !ce_lo_n && !ce_hi_n && !oe_n && we_n)
      |=> (rdata == {$past(odd_rd), $past(even_rd)}));

  // R1
  lo_even_read_chk: assert property (@(posedge clk) disable iff (rst)
    (!attr_sel && !ce_lo_n && ce_hi_n && !oe_n && we_n && !a0)
      |=> (lo_en && !hi_en && rdata[BW-1:0] == $past(even_rd)));

  // R7
  vpp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (!vpp_ok_even || !vpp_ok_odd) |=> ((!$past(vpp_ok_even) -> !even_we) && (!$past(vpp_ok_odd) -> !odd_we)));

  // R6
  attr_no_bank_chk: assert property (@(posedge clk) disable iff (rst)
    attr_sel |=> (!even_we && !odd_we));

  // R8
  write_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (even_we || odd_we || attr_we) |-> (!lo_en && !hi_en));
endmodule

bind pc_lane_steer pc_lane_steer_chk #(.BW(BW)) chk_i (
  .clk(clk), .rst(rst), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .a0(a0),
  .oe_n(oe_n), .we_n(we_n), .attr_sel(attr_sel),
  .vpp_ok_even(vpp_ok_even), .vpp_ok_odd(vpp_ok_odd),
  .even_rd(even_rd), .odd_rd(odd_rd), .rdata(rdata),
  .lo_en(lo_en), .hi_en(hi_en),
  .even_we(even_we), .odd_we(odd_we), .attr_we(attr_we)
);

// File: tb/pc_lane_steer_tb_top.sv
module pc_lane_steer_tb_top;
  localparam int BW = 8;
  localparam int DW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ce_lo_n = 1, ce_hi_n = 1, a0 = 0, oe_n = 1, we_n = 1, attr_sel = 0;
  logic vpp_ok_even = 0, vpp_ok_odd = 0;
  logic [DW-1:0] wdata = '0;
  logic [BW-1:0] even_rd = '0, odd_rd = '0, attr_rd = '0;
  logic [DW-1:0] rdata;
  logic lo_en, hi_en, even_we, odd_we, attr_we;
  logic [BW-1:0] even_wd, odd_wd, attr_wd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pc_lane_steer dut_i (
    .clk(clk), .rst(rst), .ce_lo_n(ce_lo_n), .ce_hi_n(ce_hi_n), .a0(a0),
    .oe_n(oe_n), .we_n(we_n), .attr_sel(attr_sel),
    .vpp_ok_even(vpp_ok_even), .vpp_ok_odd(vpp_ok_odd), .wdata(wdata),
    .even_rd(even_rd), .odd_rd(odd_rd), .attr_rd(attr_rd),
    .rdata(rdata), .lo_en(lo_en), .hi_en(hi_en),
    .even_we(even_we), .even_wd(even_wd), .odd_we(odd_we), .odd_wd(odd_wd),
    .attr_we(attr_we), .attr_wd(attr_wd)
  );

  // expected outputs packed: rdata, lo_en, hi_en, ew, ewd, ow, owd, aw, awd
  function automatic logic [48:0] expect_out();
    logic lo, hi, rd, wr;
    logic [15:0] r;
    logic le, he, ew, ow, aw;
    logic [7:0] ewd, owd, awd;
    lo = !ce_lo_n; hi = !ce_hi_n;
    wr = (lo || hi) && !we_n;
    rd = (lo || hi) && we_n && !oe_n;
    r = '0; le = 0; he = 0; ew = 0; ow = 0; aw = 0; ewd = 0; owd = 0; awd = 0;
    if (rd) begin
      if (lo) begin
        le = 1;
        if (attr_sel) r[7:0] = (!hi && a0) ? 8'hFF : attr_rd;
        else          r[7:0] = (!hi && a0) ? odd_rd : even_rd;
      end
      if (hi) begin
        he = 1;
        r[15:8] = attr_sel ? 8'hFF : odd_rd;
      end
    end
    if (wr) begin
      if (attr_sel) begin
        if (lo && (hi || !a0)) begin aw = 1; awd = wdata[7:0]; end
      end else if (lo && hi) begin
        if (vpp_ok_even) begin ew = 1; ewd = wdata[7:0]; end
        if (vpp_ok_odd)  begin ow = 1; owd = wdata[15:8]; end
      end else if (lo) begin
        if (!a0 && vpp_ok_even) begin ew = 1; ewd = wdata[7:0]; end
        if (a0 && vpp_ok_odd)   begin ow = 1; owd = wdata[7:0]; end
      end else if (hi) begin
        if (vpp_ok_odd) begin ow = 1; owd = wdata[15:8]; end
      end
    end
    return {r, le, he, ew, ewd, ow, owd, aw, awd};
  endfunction

  function automatic string tag_of();
    logic lo, hi;
    lo = !ce_lo_n; hi = !ce_hi_n;
    if (!lo && !hi) return "R4 standby";
    if (!we_n) begin
      if (attr_sel) return "R6 attr write";
      if (!oe_n) return "R8 oe+we write";
      if (!vpp_ok_even || !vpp_ok_odd) return "R7 vpp gated write";
      return "R5 common write";
    end
    if (oe_n) return "R4 idle";
    if (attr_sel) return "R6 attr read";
    if (lo && hi) return "R3 word read";
    if (hi) return "R2 high read";
    return "R1 low read";
  endfunction

  task automatic apply(input logic lo_n, input logic hi_n, input logic a, input logic oen,
                       input logic wen, input logic at, input logic ve, input logic vo);
    logic [48:0] exp_v, act_v;
    string t;
    ce_lo_n = lo_n; ce_hi_n = hi_n; a0 = a; oe_n = oen; we_n = wen; attr_sel = at;
    vpp_ok_even = ve; vpp_ok_odd = vo;
    wdata = 16'($urandom); even_rd = 8'($urandom); odd_rd = 8'($urandom); attr_rd = 8'($urandom);
    exp_v = expect_out();
    t = tag_of();
    @(posedge clk);
    @(negedge clk);
    act_v = {rdata, lo_en, hi_en, even_we, even_wd, odd_we, odd_wd, attr_we, attr_wd};
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", t, act_v, exp_v);
    end
  endtask

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R9 reset state
    n_chk++;
    if ({rdata, lo_en, hi_en, even_we, odd_we, attr_we, even_wd, odd_wd, attr_wd} !== '0) begin
      n_bad++;
      $display("FAIL R9 reset: actual %h expected 0", {rdata, lo_en, hi_en});
    end
    rst = 1'b0;
    // directed corners: lo_n hi_n a0 oe_n we_n attr vppE vppO
    apply(0,1,0,0,1,0,1,1); // R1 even on low lane
    apply(0,1,1,0,1,0,1,1); // R1 odd on low lane
    apply(1,0,0,0,1,0,1,1); // R2
    apply(1,0,1,0,1,0,1,1); // R2 a0 ignored
    apply(0,0,1,0,1,0,1,1); // R3
    apply(1,1,0,0,0,0,1,1); // R4 standby
    apply(0,0,0,1,1,0,1,1); // R4 idle
    apply(0,1,0,1,0,0,1,1); // R5 even
    apply(0,1,1,1,0,0,1,1); // R5 odd via low
    apply(1,0,0,1,0,0,1,1); // R5 high
    apply(0,0,0,1,0,0,1,1); // R5 word
    apply(0,0,0,1,0,0,0,1); // R7 even gated
    apply(0,0,0,1,0,0,1,0); // R7 odd gated
    apply(0,1,1,0,1,1,1,1); // R6 attr odd read FF
    apply(0,1,0,0,1,1,1,1); // R6 attr even read
    apply(0,0,0,0,1,1,1,1); // R6 attr word read
    apply(0,1,1,1,0,1,1,1); // R6 attr odd write ignored
    apply(0,1,0,1,0,1,0,0); // R6 attr even write
    apply(0,0,0,0,0,0,1,1); // R8 both enables low
    for (int i = 0; i < 600; i++) begin
      apply(1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 1)), 1'($urandom),
            1'($urandom_range(0, 2) == 0), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 4) != 0),
            1'($urandom_range(0, 4) != 0));
    end
    // R9 reset again clears outputs
    apply(0,0,0,0,1,0,1,1);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    n_chk++;
    if ({rdata, lo_en, hi_en} !== '0) begin
      n_bad++;
      $display("FAIL R9 reset clear: actual %h expected 0", {rdata, lo_en, hi_en});
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule